// File: doc/BRIEF.md
# Line-Locked Pixel Clock Control Path

This block is the digital half of a line-locked clock synthesizer. The oscillator, charge pump and loop filter sit outside. The block runs on the oscillator's output clock (`clk_vco`) and produces four things:

- a pixel clock, by dividing that clock by a selectable power of two;
- a feedback event, by counting pixel clocks;
- a reference event, taken either from a divided crystal-oscillator input or from a chosen edge of the horizontal sync input;
- pump-up and pump-down requests from a two-flop phase-frequency detector.

During a coast window, set by the vertical sync input and its polarity bit, both pump requests are held inactive. The two sync inputs are also retimed onto the pixel clock. A single output enable controls the pixel clock and the two retimed syncs together.

Configuration arrives on parallel inputs. The feedback modulus, the reference modulus and the post-divider selection are staged. They take effect only on a commit pulse. A commit also restarts every divider counter and clears the detector, so the loop never sees a clipped or stretched first cycle. The coast bits, the input select, the sync edge select and the output enable act directly.

Top module: `lpll_ctrl`

## Requirements
- R1: The post-divider selection code gives a pixel clock period of 2, 4, 8 or 16 `clk_vco` cycles for codes 0, 1, 2 and 3, with the clock high for the first half of each period. After reset the code is 0.
- R2: The feedback modulus is the committed 12-bit code plus 8, counted in pixel clocks. The reset code is 4. After a commit, with no reference event, `pfd_dn` rises exactly (code+8) × (post-divider period) `clk_vco` edges after the commit edge.
- R3: With `cfg_ref_hsync`=0, a reference event occurs on every (code+2)-th rising edge of `osc_in`. The code is the committed 7-bit reference code, 1 at reset. Counting starts from the commit.
- R4: `cfg_ref_hsync`=1 takes reference events from `hsync_in` and ignores `osc_in`. A value of 0 takes them from the divided `osc_in` and ignores `hsync_in`.
- R5: `cfg_hs_fall`=0 makes a rising edge of `hsync_in` the reference event, and a falling edge is ignored. A value of 1 selects the falling edge.
- R6: With `cfg_cp_always`=1 the pump outputs always follow the detector. With it at 0, both outputs are forced low while the synchronized `vsync_in` equals `cfg_coast_high`, so that low is the coast level for 0 and high is the coast level for 1. Coasting does not erase the detector state.
- R7: A reference event sets `pfd_up` and a feedback event sets `pfd_dn`. When both are set they clear together, so the two are never high at once.
- R8: `out_oe` is 0 after reset and follows `cfg_out_en` one cycle later. While it is 0, `pix_clk`, `hs_out` and `vs_out` are held low.
- R9: `hs_out` and `vs_out` copy the sync inputs after a two-flop synchronizer. They change only on rising edges of the pixel clock.
- R10: The staged codes take effect only on `cfg_commit`. Code inputs changed without a commit have no effect. A commit restarts every divider from zero and clears the detector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_vco | input | 1 | Oscillator output clock; all logic runs on it |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_in | input | 1 | Crystal oscillator reference, asynchronous |
| hsync_in | input | 1 | Horizontal sync, asynchronous |
| vsync_in | input | 1 | Vertical sync, asynchronous; gates coasting |
| cfg_fb_code | input | 12 | Staged feedback code; modulus = code + 8 |
| cfg_ref_code | input | 7 | Staged oscillator divider code; modulus = code + 2 |
| cfg_post_sel | input | 2 | Staged post-divider code: 0→2, 1→4, 2→8, 3→16 |
| cfg_ref_hsync | input | 1 | Reference source: 1 horizontal sync, 0 divided oscillator |
| cfg_hs_fall | input | 1 | Sync reference edge: 0 rising, 1 falling |
| cfg_cp_always | input | 1 | 1 disables coasting |
| cfg_coast_high | input | 1 | Vertical sync level that coasts: 0 low, 1 high |
| cfg_out_en | input | 1 | Output enable request |
| cfg_commit | input | 1 | One-cycle pulse loading staged codes and restarting counters |
| pix_clk | output | 1 | Pixel clock, low when disabled |
| hs_out | output | 1 | Retimed horizontal sync |
| vs_out | output | 1 | Retimed vertical sync |
| out_oe | output | 1 | Enable for the output pad drivers |
| pfd_up | output | 1 | Pump-up request |
| pfd_dn | output | 1 | Pump-down request |

## Verification
A wrong feedback or reference count shows at the ports as a shifted pump-down or pump-up rising edge. Because every commit restarts the counters from a known point, the shift is visible on the first event, exactly (code+8) × period cycles later. A wrong post-divider state shows within one pixel period as a wrong high or low run on `pix_clk`. Wrong detector or coast state appears within a few cycles: either both pump outputs are high together, or a request that was set earlier reappears when the coast window closes.

// File: rtl/lpll_pkg.sv
// Package: shared defaults and the post-divider code names for the
// line-locked clock control path.
package lpll_pkg;
    localparam int LPLL_FB_W      = 12;  // feedback code width
    localparam int LPLL_REF_W     = 7;   // oscillator divider code width
    localparam int LPLL_POST_W    = 2;   // post-divider select width
    localparam int LPLL_FB_OFS    = 8;   // modulus = feedback code + offset
    localparam int LPLL_REF_OFS   = 2;   // modulus = reference code + offset
    localparam int LPLL_SYNC_STG  = 2;   // synchronizer depth
    localparam int LPLL_FB_RST    = 4;   // feedback code after reset
    localparam int LPLL_REF_RST   = 1;   // reference code after reset

    typedef enum logic [LPLL_POST_W-1:0] {
        POST_DIV2  = 2'd0,
        POST_DIV4  = 2'd1,
        POST_DIV8  = 2'd2,
        POST_DIV16 = 2'd3
    } post_sel_e;
endpackage

// File: rtl/lpll_sync.sv
// Multi-bit level synchronizer.
// Each bit passes through STAGES flops on clk. The bits are independent
// single-bit levels. Assumes STAGES >= 2 and that no bus coherence is needed.
module lpll_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    logic [STAGES-1:0][N-1:0] stg;

    // Shift the asynchronous levels through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg <= '0;
        end else begin
            stg[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                stg[s] <= stg[s-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/lpll_postdiv.sv
// Post-divider: divides clk by 2^(sel+1) to form the pixel clock.
// pix_ce pulses in the last clk cycle of each pixel period, so pixel-domain
// registers update on the same edge where pix_lvl rises. pix_lvl is high
// for the first half of the period. Assumes sel changes only together with
// restart.
module lpll_postdiv #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [SEL_W-1:0] sel,
    output logic             pix_ce,
    output logic             pix_lvl
);
    localparam int CNT_W = 1 << SEL_W;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   modv;
    logic [CNT_W:0]   half;

    // Decode the selected modulus and the high-phase length.
    always_comb begin
        modv = (CNT_W+1)'(1) << (int'(sel) + 1);
        half = modv >> 1;
    end

    assign pix_ce  = ({1'b0, cnt} == modv - (CNT_W+1)'(1));
    assign pix_lvl = ({1'b0, cnt} < half);

    // Free-running phase counter, restarted on commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart || pix_ce) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/lpll_modcnt.sv
// Modulo counter.
// Counts step pulses and wraps after `modulus` of them. wrap marks the step
// that completes a cycle. Assumes modulus >= 1. A count at or above
// modulus-1 is treated as the last step.
module lpll_modcnt #(
    parameter int W = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic         step,
    input  logic [W-1:0] modulus,
    output logic         wrap,
    output logic [W-1:0] count
);
    logic last;

    assign last = (count >= modulus - W'(1));
    assign wrap = step && last;

    // Advance on each step; reload from zero on restart or wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (restart) begin
            count <= '0;
        end else if (step) begin
            count <= last ? '0 : count + W'(1);
        end
    end
endmodule

// File: rtl/lpll_pfd.sv
// Two-flop phase-frequency detector with a coast gate.
// A reference event sets up_q and a feedback event sets dn_q. When both
// would be set, both clear. coast forces the outputs low but keeps the state.
module lpll_pfd (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic ref_evt,
    input  logic fb_evt,
    input  logic coast,
    output logic up,
    output logic dn
);
    logic up_q, dn_q;
    logic nxt_up, nxt_dn;

    // Candidate next state before the mutual reset.
    always_comb begin
        nxt_up = up_q | ref_evt;
        nxt_dn = dn_q | fb_evt;
    end

    // Detector flops; both clear together when both are set.
    always_ff @(posedge clk) begin
        if (!rst_n || clear || (nxt_up && nxt_dn)) begin
            up_q <= 1'b0;
            dn_q <= 1'b0;
        end else begin
            up_q <= nxt_up;
            dn_q <= nxt_dn;
        end
    end

    assign up = up_q & ~coast;
    assign dn = dn_q & ~coast;
endmodule

// File: rtl/lpll_ctrl.sv
// Top of the line-locked clock digital control path.
// All logic runs on clk_vco. The pixel clock is a clock enable plus a level
// output. The feedback, reference and post-divider codes are staged and
// loaded on cfg_commit, which also restarts the counters and clears the
// detector. Assumes the sync and oscillator inputs are asynchronous and
// slower than half the clk_vco rate.
module lpll_ctrl
    import lpll_pkg::*;
#(
    parameter int FB_W        = LPLL_FB_W,
    parameter int REF_W       = LPLL_REF_W,
    parameter int POST_W      = LPLL_POST_W,
    parameter int FB_OFS      = LPLL_FB_OFS,
    parameter int REF_OFS     = LPLL_REF_OFS,
    parameter int SYNC_STAGES = LPLL_SYNC_STG,
    parameter int FB_RST      = LPLL_FB_RST,
    parameter int REF_RST     = LPLL_REF_RST
) (
    input  logic              clk_vco,
    input  logic              rst_n,
    input  logic              osc_in,
    input  logic              hsync_in,
    input  logic              vsync_in,
    input  logic [FB_W-1:0]   cfg_fb_code,
    input  logic [REF_W-1:0]  cfg_ref_code,
    input  logic [POST_W-1:0] cfg_post_sel,
    input  logic              cfg_ref_hsync,
    input  logic              cfg_hs_fall,
    input  logic              cfg_cp_always,
    input  logic              cfg_coast_high,
    input  logic              cfg_out_en,
    input  logic              cfg_commit,
    output logic              pix_clk,
    output logic              hs_out,
    output logic              vs_out,
    output logic              out_oe,
    output logic              pfd_up,
    output logic              pfd_dn
);
    localparam int FBM_W  = FB_W + 1;
    localparam int REFM_W = REF_W + 1;

    logic [FB_W-1:0]   fb_code_q;
    logic [REF_W-1:0]  ref_code_q;
    logic [POST_W-1:0] post_sel_q;
    logic [FBM_W-1:0]  fb_mod, fb_cnt;
    logic [REFM_W-1:0] ref_mod, ref_cnt;
    logic [2:0]        sync_lvl;
    logic              osc_s, hs_s, vs_s, osc_d, hs_d;
    logic              osc_rise, hs_evt, ref_evt, ref_wrap, fb_evt;
    logic              pix_ce, pix_raw, coast;
    logic              hs_q, vs_q, oe_q;

    // Active divider codes, loaded only on commit.
    always_ff @(posedge clk_vco) begin
        if (!rst_n) begin
            fb_code_q  <= FB_W'(FB_RST);
            ref_code_q <= REF_W'(REF_RST);
            post_sel_q <= '0;
        end else if (cfg_commit) begin
            fb_code_q  <= cfg_fb_code;
            ref_code_q <= cfg_ref_code;
            post_sel_q <= cfg_post_sel;
        end
    end

    assign fb_mod  = {1'b0, fb_code_q}  + FBM_W'(FB_OFS);
    assign ref_mod = {1'b0, ref_code_q} + REFM_W'(REF_OFS);

    lpll_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk_vco),
        .rst_n (rst_n),
        .d     ({vsync_in, hsync_in, osc_in}),
        .q     (sync_lvl)
    );

    assign osc_s = sync_lvl[0];
    assign hs_s  = sync_lvl[1];
    assign vs_s  = sync_lvl[2];

    // Previous synchronized levels for edge detection.
    always_ff @(posedge clk_vco) begin
        if (!rst_n) begin
            osc_d <= 1'b0;
            hs_d  <= 1'b0;
        end else begin
            osc_d <= osc_s;
            hs_d  <= hs_s;
        end
    end

    assign osc_rise = osc_s & ~osc_d;
    assign hs_evt   = cfg_hs_fall ? (hs_d & ~hs_s) : (hs_s & ~hs_d);

    lpll_postdiv #(.SEL_W(POST_W)) u_post (
        .clk     (clk_vco),
        .rst_n   (rst_n),
        .restart (cfg_commit),
        .sel     (post_sel_q),
        .pix_ce  (pix_ce),
        .pix_lvl (pix_raw)
    );

    lpll_modcnt #(.W(FBM_W)) u_fbdiv (
        .clk     (clk_vco),
        .rst_n   (rst_n),
        .restart (cfg_commit),
        .step    (pix_ce),
        .modulus (fb_mod),
        .wrap    (fb_evt),
        .count   (fb_cnt)
    );

    lpll_modcnt #(.W(REFM_W)) u_refdiv (
        .clk     (clk_vco),
        .rst_n   (rst_n),
        .restart (cfg_commit),
        .step    (osc_rise),
        .modulus (ref_mod),
        .wrap    (ref_wrap),
        .count   (ref_cnt)
    );

    assign ref_evt = cfg_ref_hsync ? hs_evt : ref_wrap;
    assign coast   = ~cfg_cp_always & (vs_s == cfg_coast_high);

    lpll_pfd u_pfd (
        .clk     (clk_vco),
        .rst_n   (rst_n),
        .clear   (cfg_commit),
        .ref_evt (ref_evt),
        .fb_evt  (fb_evt),
        .coast   (coast),
        .up      (pfd_up),
        .dn      (pfd_dn)
    );

    // Retime the synchronized syncs onto the pixel clock edge.
    always_ff @(posedge clk_vco) begin
        if (!rst_n) begin
            hs_q <= 1'b0;
            vs_q <= 1'b0;
        end else if (pix_ce) begin
            hs_q <= hs_s;
            vs_q <= vs_s;
        end
    end

    // Register the shared output enable.
    always_ff @(posedge clk_vco) begin
        if (!rst_n) begin
            oe_q <= 1'b0;
        end else begin
            oe_q <= cfg_out_en;
        end
    end

    assign out_oe  = oe_q;
    assign pix_clk = pix_raw & oe_q;
    assign hs_out  = hs_q & oe_q;
    assign vs_out  = vs_q & oe_q;
endmodule

// File: rtl/lpll_ctrl_chk.sv
// Assertion checker for lpll_ctrl, attached by the bind at the end of this
// file. It watches the ports and the divider state. Periods are measured
// with its own counters.
module lpll_ctrl_chk #(
    parameter int FB_W   = 12,
    parameter int REF_W  = 7,
    parameter int POST_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              vsync_in,
    input logic              cfg_cp_always,
    input logic              cfg_coast_high,
    input logic              cfg_commit,
    input logic              pfd_up,
    input logic              pfd_dn,
    input logic              out_oe,
    input logic              pix_raw,
    input logic              hs_out,
    input logic              vs_out,
    input logic [POST_W-1:0] post_sel_q,
    input logic [FB_W:0]     fb_cnt,
    input logic [FB_W:0]     fb_mod,
    input logic [REF_W:0]    ref_cnt,
    input logic [REF_W:0]    ref_mod
);
    localparam int GAP_W = (1 << POST_W) + 2;

    logic             pix_prev, seen;
    logic [GAP_W-1:0] gap;
    logic [1:0]       age;
    logic             pix_rise;

    assign pix_rise = pix_raw && !pix_prev;

    // Track clk cycles between pixel clock rises; invalidate across a commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_prev <= 1'b0;
            seen     <= 1'b0;
            gap      <= '0;
        end else begin
            pix_prev <= pix_raw;
            if (pix_rise) begin
                gap  <= GAP_W'(1);
                seen <= !cfg_commit;
            end else begin
                gap <= (gap == '1) ? gap : gap + GAP_W'(1);
                if (cfg_commit) seen <= 1'b0;
            end
        end
    end

    // Cycles since reset, saturating, so that history checks stay valid.
    always_ff @(posedge clk) begin
        if (!rst_n) age <= '0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    p_pix_period_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && pix_rise) |-> (gap == (GAP_W'(1) << (int'(post_sel_q) + 1))));

    p_fb_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fb_cnt < fb_mod);

    p_ref_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ref_cnt < ref_mod);

    p_coast_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3 && !cfg_cp_always && vsync_in == cfg_coast_high &&
         $past(vsync_in) == cfg_coast_high && $past(vsync_in, 2) == cfg_coast_high)
        |-> (!pfd_up && !pfd_dn));

    p_pump_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(pfd_up && pfd_dn));

    p_oe_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !out_oe);

    p_sync_on_pix_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_oe && $past(out_oe) && (!$stable(hs_out) || !$stable(vs_out)))
        |-> (pix_raw && !$past(pix_raw)));
endmodule

bind lpll_ctrl lpll_ctrl_chk #(
    .FB_W   (FB_W),
    .REF_W  (REF_W),
    .POST_W (POST_W)
) u_chk (
    .clk            (clk_vco),
    .rst_n          (rst_n),
    .vsync_in       (vsync_in),
    .cfg_cp_always  (cfg_cp_always),
    .cfg_coast_high (cfg_coast_high),
    .cfg_commit     (cfg_commit),
    .pfd_up         (pfd_up),
    .pfd_dn         (pfd_dn),
    .out_oe         (out_oe),
    .pix_raw        (pix_raw),
    .hs_out         (hs_out),
    .vs_out         (vs_out),
    .post_sel_q     (post_sel_q),
    .fb_cnt         (fb_cnt),
    .fb_mod         (fb_mod),
    .ref_cnt        (ref_cnt),
    .ref_mod        (ref_mod)
);

// File: tb/sim_lpll_ctrl.sv
// Scoreboard bench for lpll_ctrl.
// Stimulus tasks push expected measurements. Monitor tasks measure at the
// ports, pop the expectation and compare.
module sim_lpll_ctrl;
    import lpll_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        osc_in = 1'b0, hsync_in = 1'b0, vsync_in = 1'b0;
    logic [11:0] cfg_fb_code = 12'd4;
    logic [6:0]  cfg_ref_code = 7'd1;
    logic [1:0]  cfg_post_sel = 2'd0;
    logic        cfg_ref_hsync = 1'b0, cfg_hs_fall = 1'b0;
    logic        cfg_cp_always = 1'b1, cfg_coast_high = 1'b0;
    logic        cfg_out_en = 1'b0, cfg_commit = 1'b0;
    logic        pix_clk, hs_out, vs_out, out_oe, pfd_up, pfd_dn;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        string tag;
        int    val;
    } exp_t;
    exp_t sb_q[$];

    always #4 clk = ~clk;   // 125 MHz

    lpll_ctrl u0 (
        .clk_vco(clk), .rst_n(rst_n), .osc_in(osc_in), .hsync_in(hsync_in),
        .vsync_in(vsync_in), .cfg_fb_code(cfg_fb_code), .cfg_ref_code(cfg_ref_code),
        .cfg_post_sel(cfg_post_sel), .cfg_ref_hsync(cfg_ref_hsync),
        .cfg_hs_fall(cfg_hs_fall), .cfg_cp_always(cfg_cp_always),
        .cfg_coast_high(cfg_coast_high), .cfg_out_en(cfg_out_en),
        .cfg_commit(cfg_commit), .pix_clk(pix_clk), .hs_out(hs_out),
        .vs_out(vs_out), .out_oe(out_oe), .pfd_up(pfd_up), .pfd_dn(pfd_dn)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic sb_expect(input string tag, input int val);
        exp_t e;
        e.tag = tag;
        e.val = val;
        sb_q.push_back(e);
    endtask

    task automatic sb_compare(input int act);
        exp_t e;
        e = sb_q.pop_front();
        check(e.tag, act, e.val);
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Load staged codes with a one-cycle commit. Returns at the negedge
    // after the commit edge.
    task automatic commit(input int fb, input int rf, input int ps);
        cfg_fb_code  = 12'(fb);
        cfg_ref_code = 7'(rf);
        cfg_post_sel = 2'(ps);
        cfg_commit   = 1'b1;
        @(negedge clk);
        cfg_commit   = 1'b0;
    endtask

    // Monitor: pixel period and high time between two later rises.
    task automatic mon_period();
        int per = 0, hi = 0;
        while (!(pix_clk == 1'b0)) @(negedge clk);
        while (!(pix_clk == 1'b1)) @(negedge clk);
        while (!(pix_clk == 1'b0)) @(negedge clk);
        while (!(pix_clk == 1'b1)) @(negedge clk);
        do begin
            per++;
            if (pix_clk) hi++;
            @(negedge clk);
        end while (!(pix_clk == 1'b1 && per > 0 && hi < per));
        sb_compare(per);
        sb_compare(hi);
    endtask

    // Monitor: clk edges from the commit edge until pfd_dn is seen high.
    task automatic mon_dn_latency();
        int n = 0;
        while (!pfd_dn && n < 20000) begin
            @(posedge clk);
            n++;
            @(negedge clk);
        end
        sb_compare(n);
    endtask

    // Monitor: index of the oscillator rise after which pfd_up is high.
    task automatic mon_osc_count(input int limit);
        int first = 0;
        for (int i = 1; i <= limit && first == 0; i++) begin
            osc_in = 1'b1;
            tick(5);
            if (pfd_up) first = i;
            osc_in = 1'b0;
            tick(5);
        end
        sb_compare(first);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(1);
        // R8: reset state
        check("R8 out_oe after reset", out_oe, 0);
        check("R8 pix_clk low while disabled", pix_clk, 0);
        check("R7 pfd_up after reset", pfd_up, 0);
        check("R7 pfd_dn after reset", pfd_dn, 0);

        cfg_out_en = 1'b1;
        tick(1);
        check("R8 out_oe follows enable", out_oe, 1);

        // R1: every post-divider code
        for (int s = 0; s < 4; s++) begin
            commit(4, 1, s);
            sb_expect("R1 pixel period", 2 << s);
            sb_expect("R1 pixel high time", 1 << s);
            mon_period();
        end

        // R2 and R10: feedback latency; uncommitted inputs ignored
        commit(4, 1, int'(POST_DIV2));
        cfg_fb_code  = 12'd100;
        cfg_post_sel = 2'd3;
        sb_expect("R10 uncommitted codes ignored, R2 code 4", 24);
        mon_dn_latency();
        commit(20, 1, int'(POST_DIV2));
        sb_expect("R2 feedback code 20", 56);
        mon_dn_latency();
        commit(4, 1, int'(POST_DIV4));
        sb_expect("R2 feedback code 4 div4", 48);
        mon_dn_latency();
        commit(4095, 1, int'(POST_DIV2));
        sb_expect("R2 feedback code max", 8206);
        mon_dn_latency();

        // R3: oscillator reference divider
        commit(4095, 1, 0);
        sb_expect("R3 reference code 1", 3);
        mon_osc_count(12);
        commit(4095, 5, 0);
        sb_expect("R3 reference code 5", 7);
        mon_osc_count(12);
        check("R7 up set without dn", pfd_dn, 0);
        tick(8300);
        check("R7 both clear after feedback event: up", pfd_up, 0);
        check("R7 both clear after feedback event: dn", pfd_dn, 0);

        // R4: unselected sources ignored
        commit(4095, 1, 0);
        hsync_in = 1'b1; tick(10); hsync_in = 1'b0; tick(10);
        check("R4 hsync ignored with oscillator selected", pfd_up, 0);
        cfg_ref_hsync = 1'b1;
        for (int i = 0; i < 4; i++) begin
            osc_in = 1'b1; tick(5); osc_in = 1'b0; tick(5);
        end
        check("R4 oscillator ignored with hsync selected", pfd_up, 0);

        // R5 and R9: sync edge and retiming
        commit(4095, 1, 0);
        hsync_in = 1'b1; tick(10);
        check("R5 rising edge sets up", pfd_up, 1);
        check("R9 hs_out follows high", hs_out, 1);
        hsync_in = 1'b0; tick(10);
        check("R9 hs_out follows low", hs_out, 0);
        cfg_hs_fall = 1'b1;
        commit(4095, 1, 0);
        check("R10 commit clears detector", pfd_up, 0);
        hsync_in = 1'b1; tick(10);
        check("R5 rising edge ignored in falling mode", pfd_up, 0);
        hsync_in = 1'b0; tick(10);
        check("R5 falling edge sets up", pfd_up, 1);
        cfg_hs_fall = 1'b0;

        // R6: coast gating
        cfg_cp_always = 1'b0; cfg_coast_high = 1'b0; vsync_in = 1'b0;
        tick(5);
        commit(4095, 1, 0);
        hsync_in = 1'b1; tick(10);
        check("R6 coast while vsync low", pfd_up, 0);
        vsync_in = 1'b1; tick(10);
        check("R6 coast released, state kept", pfd_up, 1);
        check("R9 vs_out follows high", vs_out, 1);
        cfg_coast_high = 1'b1; tick(1);
        check("R6 coast while vsync high", pfd_up, 0);
        cfg_cp_always = 1'b1; tick(1);
        check("R6 pump always enabled", pfd_up, 1);

        // R8: disable holds outputs low
        cfg_out_en = 1'b0;
        tick(1);
        check("R8 out_oe drops", out_oe, 0);
        begin
            int seen_hi = 0;
            for (int i = 0; i < 40; i++) begin
                if (pix_clk || hs_out || vs_out) seen_hi++;
                tick(1);
            end
            check("R8 outputs held low while disabled", seen_hi, 0);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule